// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block lets an external master borrow the system bus. The external master pulls an active-low takeover request. The controller brings that asynchronous request into the clock domain. It waits until the local bus controller reports a cycle boundary with no transfer in progress. It then floats the local bus drivers and answers with an active-low takeover acknowledge. While the bus is lent out, the core may still want an external memory cycle. The controller reports this on an active-low "core needs bus" output so that the external master can give the bus back early.

A protocol enable input switches the whole handshake on or off. While the enable is set, a lock output tells the port-configuration logic to keep the three shared pins in their handshake roles and to discard any reconfiguration attempt. The lock stays set until the bus drivers have been restored. When the enable is clear, the takeover request has no effect and both active-low outputs stay high.

Top module: `bus_hold_ctl`

## Requirements
- R1: During and right after reset, take_ack_n and core_need_n are 1, bus_float is 0, and pins_locked equals hold_en.
- R2: With hold_en=1 and bus_idle=1, take_ack_n goes low at the third rising edge after take_req_n is driven low. Two of those edges are synchronizer stages and one is the state register.
- R3: The acknowledge is granted only on an edge where bus_idle is 1. While bus_idle stays 0, take_ack_n stays 1 however long the request has been present.
- R4: bus_float is 1 in every cycle in which take_ack_n is 0.
- R5: core_need_n goes low only while take_ack_n is low. If cyc_pending is 1 on the granting edge, both go low on the same edge. If cyc_pending rises later, core_need_n goes low on the next edge.
- R6: Once low, core_need_n stays low while the request remains, even if cyc_pending drops.
- R7: take_ack_n and core_need_n go high on the same edge, the third rising edge after take_req_n returns high. bus_float stays 1 for exactly one further cycle and then returns to 0.
- R8: With hold_en=0, take_req_n is ignored: take_ack_n, core_need_n and bus_float stay at 1, 1 and 0.
- R9: pins_locked is 1 whenever hold_en is 1, and also while bus_float is 1.
- R10: hold_en is not synchronized. Clearing it during a grant raises take_ack_n and core_need_n on the next edge, and restores drive one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_en | input | 1 | Protocol enable bit from the control register |
| take_req_n | input | 1 | Asynchronous active-low bus takeover request from the external master |
| cyc_pending | input | 1 | Core has an external memory cycle waiting |
| bus_idle | input | 1 | Local bus controller is at a cycle boundary with nothing in flight |
| take_ack_n | output | 1 | Active-low acknowledge: the bus has been released |
| core_need_n | output | 1 | Active-low request from the core to get the bus back |
| bus_float | output | 1 | Tri-states the local bus drivers |
| pins_locked | output | 1 | Shared pins held in handshake roles; port reconfiguration is ignored |

## Verification
The bench sweeps the number of busy cycles that separate a synchronized request from an idle boundary. A controller that grants mid-cycle would raise the acknowledge early, and one with a missing synchronizer stage would raise it one edge early. The sweep is crossed with pending-cycle timings: none, present at the grant, and arriving late and then dropped. A design that lets core_need_n lead the acknowledge or follow cyc_pending downward is caught there. The release path is timed edge by edge, which exposes drive restored together with the acknowledge. Clearing the enable mid-grant checks that the lock is held until drive returns.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    HS_RUN     = 2'd0,
    HS_GRANT   = 2'd1,
    HS_RESTORE = 2'd2
  } hold_st_t;
endpackage

// File: rtl/bh_sync.sv
module bh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bh_grant_fsm.sv
module bh_grant_fsm
  import bus_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_active,
  input  logic bus_idle,
  output logic grant_next,
  output logic granted,
  output logic floating
);
  hold_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_RUN:     if (req_active && bus_idle) st_d = HS_GRANT;
      HS_GRANT:   if (!req_active)            st_d = HS_RESTORE;
      HS_RESTORE:                             st_d = HS_RUN;
      default:                                st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_RUN;
    else        st_q <= st_d;
  end

  assign grant_next = (st_d == HS_GRANT);
  assign granted    = (st_q == HS_GRANT);
  assign floating   = (st_q != HS_RUN);
endmodule

// File: rtl/bh_need_latch.sv
module bh_need_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_next,
  input  logic cyc_pending,
  output logic need_o
);
  logic need_q;

  // Set together with or after the grant, hold until the grant ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) need_q <= 1'b0;
    else        need_q <= grant_next && (need_q || cyc_pending);
  end

  assign need_o = need_q;
endmodule

// File: rtl/bus_hold_ctl.sv
module bus_hold_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_en,
  input  logic take_req_n,
  input  logic cyc_pending,
  input  logic bus_idle,
  output logic take_ack_n,
  output logic core_need_n,
  output logic bus_float,
  output logic pins_locked
);
  logic req_sync;
  logic grant_next;
  logic granted;
  logic floating;
  logic need;

  bh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (~take_req_n),
    .sync_o  (req_sync)
  );

  bh_grant_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_active (req_sync && hold_en),
    .bus_idle   (bus_idle),
    .grant_next (grant_next),
    .granted    (granted),
    .floating   (floating)
  );

  bh_need_latch u_need (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_next  (grant_next),
    .cyc_pending (cyc_pending),
    .need_o      (need)
  );

  assign take_ack_n  = ~granted;
  assign core_need_n = ~need;
  assign bus_float   = floating;
  assign pins_locked = hold_en || floating;
endmodule

// File: rtl/bus_hold_chk.sv
module bus_hold_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_en,
  input logic bus_idle,
  input logic take_ack_n,
  input logic core_need_n,
  input logic bus_float,
  input logic pins_locked
);
  // R3
  grant_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(take_ack_n) |-> $past(bus_idle));

  // R4
  float_while_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_ack_n |-> bus_float);

  // R5
  need_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_need_n |-> !take_ack_n);

  // R6
  need_drop_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_need_n) |-> $rose(take_ack_n));

  // R7
  restore_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_ack_n) |-> (bus_float ##1 !bus_float));

  // R8
  disabled_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && take_ack_n) |=> take_ack_n);

  // R9
  lock_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en || bus_float) |-> pins_locked);
endmodule

bind bus_hold_ctl bus_hold_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_en     (hold_en),
  .bus_idle    (bus_idle),
  .take_ack_n  (take_ack_n),
  .core_need_n (core_need_n),
  .bus_float   (bus_float),
  .pins_locked (pins_locked)
);

// File: tb/bus_hold_ctl_tb.sv
module bus_hold_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_en = 1'b1;
  logic take_req_n = 1'b1;
  logic cyc_pending = 1'b0;
  logic bus_idle = 1'b1;
  logic take_ack_n, core_need_n, bus_float, pins_locked;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .take_req_n(take_req_n),
    .cyc_pending(cyc_pending), .bus_idle(bus_idle), .take_ack_n(take_ack_n),
    .core_need_n(core_need_n), .bus_float(bus_float), .pins_locked(pins_locked)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input logic ack, input logic need,
                          input logic flt);
    chk({req, " ack"}, take_ack_n, ack);
    chk({req, " need"}, core_need_n, need);
    chk({req, " float"}, bus_float, flt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_outs("R1", 1'b1, 1'b1, 1'b0);
    chk("R1 lock", pins_locked, 1'b1);
    rst_n = 1'b1;
    step();
    chk_outs("R1", 1'b1, 1'b1, 1'b0);

    // Sweep: busy cycles after request x pending mode
    for (int d = 0; d < 4; d++) begin
      for (int pm = 0; pm < 3; pm++) begin
        bus_idle = 1'b0;
        cyc_pending = (pm == 1);
        take_req_n = 1'b0;
        for (int k = 0; k < 2 + d; k++) begin
          step();
          chk_outs("R3", 1'b1, 1'b1, 1'b0);
        end
        bus_idle = 1'b1;
        step();
        // R2 / R5 grant edge
        chk("R2", take_ack_n, 1'b0);
        chk("R4", bus_float, 1'b1);
        chk("R5", core_need_n, (pm == 1) ? 1'b0 : 1'b1);
        if (pm == 2) begin
          step();
          chk("R5 late", core_need_n, 1'b1);
          cyc_pending = 1'b1;
          step();
          chk("R5 late", core_need_n, 1'b0);
        end
        cyc_pending = 1'b0;
        step();
        step();
        chk("R6", core_need_n, (pm == 0) ? 1'b1 : 1'b0);
        chk("R4", bus_float, 1'b1);
        // R7 release timing
        take_req_n = 1'b1;
        step();
        step();
        chk("R7 early", take_ack_n, 1'b0);
        chk("R7 early", core_need_n, (pm == 0) ? 1'b1 : 1'b0);
        step();
        chk_outs("R7", 1'b1, 1'b1, 1'b1);
        step();
        chk_outs("R7 drive", 1'b1, 1'b1, 1'b0);
      end
    end

    // R8 disabled: request ignored
    hold_en = 1'b0;
    cyc_pending = 1'b1;
    step();
    chk("R9 unlocked", pins_locked, 1'b0);
    take_req_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step();
      chk_outs("R8", 1'b1, 1'b1, 1'b0);
    end
    take_req_n = 1'b1;
    cyc_pending = 1'b0;
    repeat (3) step();

    // R10 / R9 enable cleared during grant
    hold_en = 1'b1;
    step();
    chk("R9 lock", pins_locked, 1'b1);
    cyc_pending = 1'b1;
    take_req_n = 1'b0;
    repeat (3) step();
    chk_outs("R10 grant", 1'b0, 1'b0, 1'b1);
    hold_en = 1'b0;
    chk("R9 float lock", pins_locked, 1'b1);
    step();
    chk_outs("R10", 1'b1, 1'b1, 1'b1);
    chk("R9 restore lock", pins_locked, 1'b1);
    step();
    chk_outs("R10 drive", 1'b1, 1'b1, 1'b0);
    chk("R9 unlock", pins_locked, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule